// File: doc/BRIEF.md
# I2C Slave Direction and Access Guard

This block sits beside the byte shifter of an I2C slave and owns the transmit/receive direction. Software asks for a direction by writing a request bit in a control register. The block decides when that request becomes the effective direction that the shifter and the acknowledge logic use. While the bus sits just after an acknowledge slot or a stop, a new request applies at once. At any other time the request is parked and adopted at the next ninth SCL rising edge or stop. The result of this rule is that a slave left in transmit across a repeated start will not acknowledge its own address.

The block also stretches SCL low after each byte the slave takes part in. It releases SCL on the software sequence for each direction. In slave transmit it closes the register port for a short time after each ninth clock, unless a function-control field turns that lockout off. SCL arrives already synchronized, start and stop arrive as one-cycle detect pulses, and the register port is a plain read/write strobe bus with combinational read data.

Top module: `i2c_sdir_ctrl`

## Requirements
- R1: `bit_cnt` is 0 after reset, start (including repeated start) or stop. It increments on each SCL rising edge and returns to 0 on the rising edge seen while it equals 8 (the ninth clock).
- R2: The immediate-effect window is open after reset. It is opened by a ninth-clock rising edge or a stop, and closed by any other SCL rising edge.
- R3: A control-register write made while the window is open sets `dir_eff` to written bit 7 in the next cycle.
- R4: A control-register write made while the window is closed leaves `dir_eff` unchanged. The latest request (bit 7) is adopted in the cycle after the next ninth-clock rising edge or stop.
- R5: While `bit_cnt` is 8, `ack_drive` is 1 only if `dir_eff` is 0 and either the byte is the first since a start and `addr_match` is 1, or the slave is already addressed. With `dir_eff` left at 1 across a repeated start, the address is not acknowledged.
- R6: The slave becomes addressed at the ninth clock of the address byte if `addr_match` is 1, and is cleared by start or stop. `scl_hold` rises in the cycle after the SCL falling edge that follows a ninth clock, only when addressed.
- R7: Once held, SCL is released in the cycle after either a data-register read that follows a control write with bit 7 = 0, or a data-register write. A stop releases it unconditionally. A data read alone does not release it.
- R8: A ninth-clock rising edge seen with `dir_eff` = 1 raises `lockout` for the next 6 cycles. During those cycles, data-register reads and control-register reads return 0 and have no side effect, and control writes are discarded.
- R9: With control bits [1:0] = 2'b11 the ninth clock raises no lockout.
- R10: `reg_sel` 0 selects the data register, which reads `rx_byte`. `reg_sel` 1 selects the control register: bit 7 is the direction request, bits 6:0 are stored as written, and bits 1:0 form the function-control field. `reg_rdata` is 0 when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized SCL level |
| start_det | input | 1 | One-cycle pulse on start or repeated start |
| stop_det | input | 1 | One-cycle pulse on stop |
| addr_match | input | 1 | Shifter's own-address compare result |
| rx_byte | input | 8 | Received byte from the shifter |
| reg_sel | input | 1 | 0 = data register, 1 = control register |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| dir_eff | output | 1 | Effective direction, 1 = transmit |
| ack_drive | output | 1 | Slave drives SDA low for acknowledge |
| scl_hold | output | 1 | Slave holds SCL low |
| lockout | output | 1 | Register port is closed |
| bit_cnt | output | 4 | Bit position within the current byte |

## Verification
`reg_rdata` and `ack_drive` are combinational and are checked one time step after their inputs are applied, within the same cycle. `bit_cnt`, `dir_eff`, `scl_hold` and `lockout` change on the clock edge that samples the causing input, so the bench checks them after exactly one edge. The six lockout cycles are counted edge by edge, with `lockout` checked high in each of them and low just after. The deferred-direction cases check `dir_eff` both before and after the adopting edge, so both an early update and a late one are caught.

// File: rtl/sdir_pkg.sv
`timescale 1ns/1ps
package sdir_pkg;
  typedef enum logic {SEL_DATA = 1'b0, SEL_CTRL = 1'b1} reg_sel_e;
  localparam logic [1:0] FUNC_NO_LOCK = 2'b11;
endpackage

// File: rtl/sdir_bus_track.sv
`timescale 1ns/1ps
module sdir_bus_track #(
  parameter int BITS  = 9,
  localparam int CW   = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          scl_rise,
  output logic          scl_fall,
  output logic          ninth,
  output logic          win,
  output logic          addr_phase,
  output logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic scl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_in;

  assign scl_rise = scl_in & ~scl_q;
  assign scl_fall = ~scl_in & scl_q;
  assign ninth    = scl_rise && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      bit_cnt <= '0;
    else if (start_det || stop_det)  bit_cnt <= '0;
    else if (ninth)                  bit_cnt <= '0;
    else if (scl_rise)               bit_cnt <= bit_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 win <= 1'b1;
    else if (ninth || stop_det) win <= 1'b1;
    else if (scl_rise)          win <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    addr_phase <= 1'b0;
    else if (start_det)            addr_phase <= 1'b1;
    else if (stop_det || ninth)    addr_phase <= 1'b0;

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ninth |=> bit_cnt == '0);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !ninth && !start_det && !stop_det) |=> bit_cnt == $past(bit_cnt) + 1'b1);
  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    (ninth || stop_det) |=> win);
  a_r2_close: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !ninth && !stop_det) |=> !win);
endmodule

// File: rtl/sdir_dir_ctrl.sv
`timescale 1ns/1ps
module sdir_dir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic wr_dir,
  input  logic win,
  input  logic ninth,
  input  logic start_det,
  input  logic stop_det,
  input  logic addr_phase,
  input  logic addr_match,
  input  logic ack_slot,
  output logic dir_req,
  output logic dir_eff,
  output logic addressed,
  output logic ack_drive
);
  logic next_req;
  logic adopt;

  assign next_req = ctl_wr ? wr_dir : dir_req;
  assign adopt    = (ctl_wr && win) || ninth || stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dir_req <= 1'b0;
    else        dir_req <= next_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     dir_eff <= 1'b0;
    else if (adopt) dir_eff <= next_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      addressed <= 1'b0;
    else if (start_det || stop_det)  addressed <= 1'b0;
    else if (ninth && addr_phase)    addressed <= addr_match;

  assign ack_drive = ack_slot && !dir_eff && (addr_phase ? addr_match : addressed);

  a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && win) |=> dir_eff == $past(wr_dir));
  a_r4_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctl_wr && win) && !ninth && !stop_det) |=> $stable(dir_eff));
  a_r4_adopt: assert property (@(posedge clk) disable iff (!rst_n)
    (ninth && !ctl_wr) |=> dir_eff == $past(dir_req));
endmodule

// File: rtl/sdir_wait_ctrl.sv
`timescale 1ns/1ps
module sdir_wait_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ninth,
  input  logic scl_fall,
  input  logic addressed,
  input  logic stop_det,
  input  logic ctl_wr,
  input  logic wr_dir,
  input  logic data_rd,
  input  logic data_wr,
  output logic scl_hold
);
  logic ninth_seen;
  logic armed;
  logic release_now;

  assign release_now = scl_hold && (data_wr || (armed && data_rd));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   ninth_seen <= 1'b0;
    else if (ninth)               ninth_seen <= 1'b1;
    else if (scl_fall || stop_det) ninth_seen <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                    scl_hold <= 1'b0;
    else if (stop_det)                             scl_hold <= 1'b0;
    else if (scl_fall && ninth_seen && addressed)  scl_hold <= 1'b1;
    else if (release_now)                          scl_hold <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              armed <= 1'b0;
    else if (stop_det || release_now)        armed <= 1'b0;
    else if (scl_hold && ctl_wr && !wr_dir)  armed <= 1'b1;

  a_r6_hold_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> $past(scl_fall && addressed));
  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !armed && !data_wr && !stop_det) |=> scl_hold);
endmodule

// File: rtl/sdir_access_guard.sv
`timescale 1ns/1ps
module sdir_access_guard
  import sdir_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LOCK_CYC = 6,
  localparam int LW      = $clog2(LOCK_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              ninth,
  input  logic              dir_eff,
  input  logic              dir_req,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ctl_wr,
  output logic              wr_dir,
  output logic              data_rd,
  output logic              data_wr,
  output logic              locked
);
  logic [DATA_W-2:0] ctl_q;
  logic [LW-1:0]     lock_cnt;
  logic              bypass;
  logic              ctl_rd;
  logic              is_ctl;

  assign is_ctl = (reg_sel == SEL_CTRL);
  assign bypass = (ctl_q[1:0] == FUNC_NO_LOCK);
  assign locked = (lock_cnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          lock_cnt <= '0;
    else if (ninth && dir_eff && !bypass) lock_cnt <= LW'(LOCK_CYC);
    else if (locked)                     lock_cnt <= lock_cnt - 1'b1;

  assign ctl_wr  = reg_wr &&  is_ctl && !locked;
  assign ctl_rd  = reg_rd &&  is_ctl && !locked;
  assign data_rd = reg_rd && !is_ctl && !locked;
  assign data_wr = reg_wr && !is_ctl;
  assign wr_dir  = reg_wdata[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= reg_wdata[DATA_W-2:0];

  always_comb begin
    reg_rdata = '0;
    if (data_rd)     reg_rdata = rx_byte;
    else if (ctl_rd) reg_rdata = {dir_req, ctl_q};
  end

  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cnt <= LW'(LOCK_CYC));
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && reg_rd) |-> reg_rdata == '0);
  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (ninth && bypass && !locked) |=> !locked);
  a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ninth && dir_eff && !bypass) |=> locked);
endmodule

// File: rtl/i2c_sdir_ctrl.sv
`timescale 1ns/1ps
module i2c_sdir_ctrl #(
  parameter int DATA_W   = 8,
  parameter int BITS     = 9,
  parameter int LOCK_CYC = 6,
  localparam int CW      = $clog2(BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_match,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dir_eff,
  output logic              ack_drive,
  output logic              scl_hold,
  output logic              lockout,
  output logic [CW-1:0]     bit_cnt
);
  localparam logic [CW-1:0] ACK_POS = CW'(BITS - 1);

  logic scl_rise, scl_fall, ninth, win, addr_phase;
  logic ctl_wr, wr_dir, data_rd, data_wr;
  logic dir_req, addressed;

  sdir_bus_track #(.BITS(BITS)) u_track (
    .clk, .rst_n, .scl_in, .start_det, .stop_det,
    .scl_rise, .scl_fall, .ninth, .win, .addr_phase, .bit_cnt
  );

  sdir_access_guard #(.DATA_W(DATA_W), .LOCK_CYC(LOCK_CYC)) u_guard (
    .clk, .rst_n, .reg_sel, .reg_rd, .reg_wr, .reg_wdata, .rx_byte,
    .ninth, .dir_eff, .dir_req, .reg_rdata, .ctl_wr, .wr_dir,
    .data_rd, .data_wr, .locked(lockout)
  );

  sdir_dir_ctrl u_dir (
    .clk, .rst_n, .ctl_wr, .wr_dir, .win, .ninth, .start_det, .stop_det,
    .addr_phase, .addr_match, .ack_slot(bit_cnt == ACK_POS),
    .dir_req, .dir_eff, .addressed, .ack_drive
  );

  sdir_wait_ctrl u_wait (
    .clk, .rst_n, .ninth, .scl_fall, .addressed, .stop_det,
    .ctl_wr, .wr_dir, .data_rd, .data_wr, .scl_hold
  );

  a_r5_tx_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_drive && ninth) |=> !$past(dir_eff));
  a_r6_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> $past(addr_match && ninth));
endmodule

// File: tb/test_i2c_sdir_ctrl.sv
`timescale 1ns/1ps
module test_i2c_sdir_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, start_det = 1'b0, stop_det = 1'b0, addr_match = 1'b0;
  logic [7:0] rx_byte = 8'h00, reg_wdata = 8'h00;
  logic reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic dir_eff, ack_drive, scl_hold, lockout;
  logic [3:0] bit_cnt;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  i2c_sdir_ctrl i_i2c_sdir_ctrl (
    .clk, .rst_n, .scl_in, .start_det, .stop_det, .addr_match, .rx_byte,
    .reg_sel, .reg_rd, .reg_wr, .reg_wdata, .reg_rdata,
    .dir_eff, .ack_drive, .scl_hold, .lockout, .bit_cnt
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic scl_up();   scl_in = 1'b1; step(); endtask
  task automatic scl_dn();   scl_in = 1'b0; step(); endtask
  task automatic p_start();  start_det = 1'b1; step(); start_det = 1'b0; endtask
  task automatic p_stop();   stop_det = 1'b1; step(); stop_det = 1'b0; endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1; step(); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] d);
    reg_sel = sel; reg_rd = 1'b1; #1; d = reg_rdata; step(); reg_rd = 1'b0;
  endtask

  // clock bits 1..8 of a byte, checking the counter after each rise
  task automatic eight_bits(input string tag);
    for (int i = 1; i <= 8; i++) begin
      scl_up();
      check({tag, " R1 bit_cnt"}, bit_cnt, i);
      scl_dn();
    end
  endtask

  initial begin
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    checks++; fails++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    step(); step(); step();
    rst_n = 1'b1; step();
    // reset state
    check("R1 reset bit_cnt", bit_cnt, 0);
    check("R3 reset dir_eff", dir_eff, 0);
    check("R6 reset hold", scl_hold, 0);
    check("R8 reset lockout", lockout, 0);
    check("R5 reset ack", ack_drive, 0);
    check("R10 idle rdata", reg_rdata, 0);
    // R10 data register readout
    rx_byte = 8'hA5;
    rd_reg(1'b0, rd);
    check("R10 data read", rd, 8'hA5);
    // R2/R3 window open after reset
    wr_reg(1'b1, 8'h80);
    check("R3 immediate set", dir_eff, 1);
    wr_reg(1'b1, 8'h00);
    check("R3 immediate clear", dir_eff, 0);

    // A: address receive with ACK, hold, release by dir-0 write then data read
    addr_match = 1'b1;
    p_start();
    scl_dn();
    eight_bits("A");
    #1; check("R5 address ack", ack_drive, 1);
    scl_up();
    check("R1 ninth wrap", bit_cnt, 0);
    check("R8 no lock in receive", lockout, 0);
    scl_dn();
    check("R6 hold after ninth", scl_hold, 1);
    rd_reg(1'b0, rd);
    check("R7 read alone keeps hold", scl_hold, 1);
    wr_reg(1'b1, 8'h00);
    check("R7 dir write keeps hold", scl_hold, 1);
    rd_reg(1'b0, rd);
    check("R7 release after sequence", scl_hold, 0);
    wr_reg(1'b1, 8'h80);
    check("R3 window after ninth", dir_eff, 1);

    // B: transmit byte, lockout after ninth
    eight_bits("B");
    #1; check("R5 no ack in transmit", ack_drive, 0);
    scl_up();
    check("R8 lock raised", lockout, 1);
    for (int k = 1; k <= 6; k++) begin
      check("R8 lock held", lockout, 1);
      if (k == 1) begin
        reg_sel = 1'b1; reg_rd = 1'b1; #1;
        check("R8 ctl read zero", reg_rdata, 0);
        reg_rd = 1'b0;
      end
      if (k == 2) begin
        reg_sel = 1'b0; reg_rd = 1'b1; rx_byte = 8'h3C; #1;
        check("R8 data read zero", reg_rdata, 0);
        reg_rd = 1'b0;
      end
      if (k == 3) begin reg_sel = 1'b1; reg_wdata = 8'h00; reg_wr = 1'b1; end
      step();
      reg_wr = 1'b0;
    end
    check("R8 lock over", lockout, 0);
    check("R8 write discarded dir", dir_eff, 1);
    rd_reg(1'b1, rd);
    check("R8 write discarded ctl", rd, 8'h80);
    scl_dn();
    check("R6 hold in transmit", scl_hold, 1);
    wr_reg(1'b0, 8'h55);
    check("R7 data write releases", scl_hold, 0);

    // C: repeated start with direction left at transmit
    p_start();
    for (int i = 1; i <= 8; i++) begin
      scl_up();
      check("C R1 bit_cnt", bit_cnt, i);
      if (i == 1) begin
        wr_reg(1'b1, 8'h00);
        check("R4 deferred keeps dir", dir_eff, 1);
      end
      scl_dn();
    end
    #1; check("R5 no address ack after restart", ack_drive, 0);
    check("R4 still deferred", dir_eff, 1);
    scl_up();
    check("R4 adopted at ninth", dir_eff, 0);
    check("R8 lock from transmit ninth", lockout, 1);
    for (int k = 0; k < 6; k++) step();
    check("R8 lock ends", lockout, 0);
    scl_dn();
    check("R6 addressed after restart", scl_hold, 1);
    scl_up();
    p_stop();
    check("R7 stop releases", scl_hold, 0);
    check("R1 stop clears", bit_cnt, 0);

    // stop adopts a pending request
    p_start();
    scl_dn();
    scl_up();
    wr_reg(1'b1, 8'h80);
    check("R4 pending before stop", dir_eff, 0);
    p_stop();
    check("R4 adopted at stop", dir_eff, 1);

    // D: lockout bypass, not addressed
    wr_reg(1'b1, 8'h83);
    addr_match = 1'b0;
    p_start();
    scl_dn();
    eight_bits("D");
    #1; check("R5 no ack without match", ack_drive, 0);
    scl_up();
    check("R9 bypass no lock", lockout, 0);
    rd_reg(1'b1, rd);
    check("R9 ctl readable", rd, 8'h83);
    scl_dn();
    check("R6 no hold unaddressed", scl_hold, 0);
    p_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule